// File: doc/BRIEF.md
# Runtime-Configurable Asynchronous Serial Transceiver

This block moves words between on-chip logic and a host over a pair of asynchronous serial lines. Logic inside the chip pushes words into a transmit queue and pops words from a receive queue. The block serialises the outgoing words onto the transmit line and deserialises the incoming line into words. One divider drives both directions. It produces sixteen oversampling ticks per bit time. A two-bit select scales the divider so that four rates in the ratio 1:2:4:8 are available.

The frame format is set through configuration inputs and can change at runtime. The data field is 6, 7 or 8 bits. A parity bit can be added and is either even or odd. The stop length is 1, 1.5 or 2 bit times. Each direction captures the configuration when a frame starts and keeps it until that frame ends. Each received word is stored together with a parity-error flag and a framing-error flag. A one-cycle pulse marks each word that is stored. A separate pulse marks each word that is dropped because the receive queue is full.

Top module: `sio_core`

## Requirements
- R1: One oversampling tick occurs every `DIV_FAST << (3 - cfg_rate)` clock cycles. Every bit lasts 16 ticks. Code 3 is the fastest rate and code 0 the slowest.
- R2: The transmit line is high when idle and after reset. A frame starts with one low bit and ends with high stop bits.
- R3: Data travels least significant bit first. `cfg_len` gives the field width: 0 means 6 bits, 1 means 7 bits, and 2 or 3 means 8 bits. A received word is right-aligned in `rx_data`, and the unused upper bits are zero.
- R4: When `cfg_par_en` is 1, a parity bit follows the data. With `cfg_par_odd`=0 the data bits plus the parity bit hold an even number of ones. With `cfg_par_odd`=1 they hold an odd number.
- R5: On transmit, the stop time is 16 ticks for `cfg_stop`=0, 24 ticks for 1, and 32 ticks for 2 or 3. When the queue holds a further word, the next start bit follows the stop time with no gap.
- R6: The receiver samples the line on the 8th tick after it sees a falling edge. If the line is high at that point, the start is rejected and nothing is stored.
- R7: For every frame it accepts, the receiver stores the word and pulses `rx_done` for one cycle.
- R8: Both queues are first-in first-out. A push while a queue is full is ignored. A pop while a queue is empty is ignored.
- R9: If a frame completes while the receive queue is full, the word is dropped. `rx_overrun` pulses for one cycle and `rx_done` stays low.
- R10: If the first stop bit samples low, the stored word carries `rx_ferr`=1.
- R11: If the received parity bit does not match the configured parity, the stored word carries `rx_perr`=1. The flag is always 0 when parity is disabled.
- R12: A configuration change made while a frame is in progress does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rate | input | 2 | Rate select, 3 = fastest |
| cfg_len | input | 2 | Data field width code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop | input | 2 | Stop length code |
| tx_push | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 8 | Word to send, right-aligned |
| tx_full | output | 1 | Transmit queue is full |
| tx_empty | output | 1 | Transmit queue is empty |
| tx_line | output | 1 | Serial output line |
| rx_line | input | 1 | Serial input line |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 8 | Head word of the receive queue |
| rx_perr | output | 1 | Parity error flag of the head word |
| rx_ferr | output | 1 | Framing error flag of the head word |
| rx_empty | output | 1 | Receive queue is empty |
| rx_full | output | 1 | Receive queue is full |
| rx_done | output | 1 | One-cycle pulse: a word was stored |
| rx_overrun | output | 1 | One-cycle pulse: a word was dropped |

## Verification
Some internal faults show up at the ports right away. A queue pointer that goes wrong makes the receive queue's empty or full flag, or its head word, disagree with the queue model within one clock. A wrong bit counter or tick count in the transmitter changes the level of the line at the next mid-bit sample, which is at most 16 ticks later. A fault in the stop-length counter shows as a gap error at the next back-to-back start edge. A fault in the receiver's parity or shift path appears when the affected word reaches the head of the queue, together with its flags.

// File: rtl/sio_pkg.sv
package sio_pkg;

   localparam int unsigned OSR = 16;

   typedef struct packed {
      logic       ferr;
      logic       perr;
      logic [7:0] data;
   } rx_word_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } ser_state_t;

   // field width in bits from the length code
   function automatic logic [3:0] field_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 4'd6;
         2'd1:    return 4'd7;
         default: return 4'd8;
      endcase
   endfunction

   // last tick index of the stop interval on transmit
   function automatic logic [4:0] stop_last(input logic [1:0] code);
      case (code)
         2'd0:    return 5'd15;
         2'd1:    return 5'd23;
         default: return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
   parameter int unsigned DIV_FAST = 163
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] rate,
   output logic       tick
);
   localparam int unsigned MAX_DIV = DIV_FAST * 8;
   localparam int unsigned CW      = $clog2(MAX_DIV + 1);

   if (DIV_FAST < 1) begin : g_bad_div
      $error("sio_baud: DIV_FAST must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   always_comb begin
      lim  = CW'((DIV_FAST << (32'd3 - 32'(rate))) - 1);
      tick = (cnt >= lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sio_fifo.sv
module sio_fifo #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic          full,
   output logic          empty
);
   localparam int unsigned AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sio_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW:0]   wp, rp;
   logic          do_push, do_pop;

   always_comb begin
      empty   = (wp == rp);
      full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
      do_push = push && !full;
      do_pop  = pop && !empty;
      dout    = mem[rp[AW-1:0]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp[AW-1:0]] <= din;
   end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
   import sio_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rx_line,
   input  logic [1:0] cfg_len,
   input  logic       cfg_par_en,
   input  logic       cfg_par_odd,
   output logic       word_valid,
   output rx_word_t   word
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sio_rx: SYNC_STAGES must be at least 2");
   end

   // input synchroniser chain
   logic [SYNC_STAGES:0] chain;
   assign chain[0] = rx_line;
   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[g+1] <= 1'b1;
         else        chain[g+1] <= chain[g];
      end
   end

   logic       rx_s;
   assign rx_s = chain[SYNC_STAGES];

   ser_state_t st;
   logic [3:0] tcnt, bidx, nbits;
   logic       pen, podd, par_acc, perr_r;
   logic [7:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         tcnt       <= '0;
         bidx       <= '0;
         nbits      <= 4'd8;
         pen        <= 1'b0;
         podd       <= 1'b0;
         par_acc    <= 1'b0;
         perr_r     <= 1'b0;
         sr         <= '0;
         word_valid <= 1'b0;
         word       <= '0;
      end else begin
         word_valid <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (!rx_s) begin
                  st    <= ST_START;
                  tcnt  <= '0;
                  nbits <= field_bits(cfg_len);
                  pen   <= cfg_par_en;
                  podd  <= cfg_par_odd;
               end
            end
            ST_START: if (tick) begin
               if (tcnt == 4'd7) begin
                  tcnt    <= '0;
                  bidx    <= '0;
                  par_acc <= 1'b0;
                  perr_r  <= 1'b0;
                  sr      <= '0;
                  st      <= rx_s ? ST_IDLE : ST_DATA;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            ST_DATA: if (tick) begin
               if (tcnt == 4'd15) begin
                  tcnt    <= '0;
                  sr      <= {rx_s, sr[7:1]};
                  par_acc <= par_acc ^ rx_s;
                  if (bidx == nbits - 4'd1) st <= pen ? ST_PAR : ST_STOP;
                  else                      bidx <= bidx + 1'b1;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            ST_PAR: if (tick) begin
               if (tcnt == 4'd15) begin
                  tcnt   <= '0;
                  perr_r <= rx_s ^ par_acc ^ podd;
                  st     <= ST_STOP;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            ST_STOP: if (tick) begin
               if (tcnt == 4'd15) begin
                  tcnt       <= '0;
                  word_valid <= 1'b1;
                  word.data  <= sr >> (4'd8 - nbits);
                  word.ferr  <= !rx_s;
                  word.perr  <= pen && perr_r;
                  st         <= ST_IDLE;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
   import sio_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [1:0] cfg_len,
   input  logic       cfg_par_en,
   input  logic       cfg_par_odd,
   input  logic [1:0] cfg_stop,
   input  logic       q_empty,
   input  logic [7:0] q_data,
   output logic       q_pop,
   output logic       tx_line
);
   ser_state_t st;
   logic [4:0] tcnt, slast;
   logic [3:0] bidx, nbits;
   logic       pen, podd, par_acc;
   logic [7:0] sr;
   logic       load;

   // a new frame starts on a tick, from idle or right at the end of a stop
   always_comb begin
      load  = tick && !q_empty &&
              (st == ST_IDLE || (st == ST_STOP && tcnt == slast));
      q_pop = load;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         tcnt    <= '0;
         slast   <= 5'd15;
         bidx    <= '0;
         nbits   <= 4'd8;
         pen     <= 1'b0;
         podd    <= 1'b0;
         par_acc <= 1'b0;
         sr      <= '0;
         tx_line <= 1'b1;
      end else if (load) begin
         st      <= ST_START;
         tcnt    <= '0;
         bidx    <= '0;
         sr      <= q_data;
         nbits   <= field_bits(cfg_len);
         slast   <= stop_last(cfg_stop);
         pen     <= cfg_par_en;
         podd    <= cfg_par_odd;
         par_acc <= 1'b0;
         tx_line <= 1'b0;
      end else if (tick) begin
         case (st)
            ST_IDLE: tx_line <= 1'b1;
            ST_START: begin
               if (tcnt == 5'd15) begin
                  tcnt    <= '0;
                  st      <= ST_DATA;
                  tx_line <= sr[0];
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            ST_DATA: begin
               if (tcnt == 5'd15) begin
                  tcnt    <= '0;
                  par_acc <= par_acc ^ sr[0];
                  sr      <= sr >> 1;
                  if (bidx == nbits - 4'd1) begin
                     if (pen) begin
                        st      <= ST_PAR;
                        tx_line <= par_acc ^ sr[0] ^ podd;
                     end else begin
                        st      <= ST_STOP;
                        tx_line <= 1'b1;
                     end
                  end else begin
                     bidx    <= bidx + 1'b1;
                     tx_line <= sr[1];
                  end
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            ST_PAR: begin
               if (tcnt == 5'd15) begin
                  tcnt    <= '0;
                  st      <= ST_STOP;
                  tx_line <= 1'b1;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            ST_STOP: begin
               if (tcnt == slast) begin
                  tcnt <= '0;
                  st   <= ST_IDLE;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sio_core.sv
module sio_core
   import sio_pkg::*;
#(
   parameter int unsigned DIV_FAST    = 163,
   parameter int unsigned TX_DEPTH    = 16,
   parameter int unsigned RX_DEPTH    = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cfg_rate,
   input  logic [1:0] cfg_len,
   input  logic       cfg_par_en,
   input  logic       cfg_par_odd,
   input  logic [1:0] cfg_stop,
   input  logic       tx_push,
   input  logic [7:0] tx_data,
   output logic       tx_full,
   output logic       tx_empty,
   output logic       tx_line,
   input  logic       rx_line,
   input  logic       rx_pop,
   output logic [7:0] rx_data,
   output logic       rx_perr,
   output logic       rx_ferr,
   output logic       rx_empty,
   output logic       rx_full,
   output logic       rx_done,
   output logic       rx_overrun
);
   localparam int unsigned RXW = $bits(rx_word_t);

   logic       tick;
   logic       txq_pop;
   logic [7:0] txq_data;
   logic       rxw_valid;
   rx_word_t   rxw, rxq_head;

   sio_baud #(.DIV_FAST(DIV_FAST)) u_baud (
      .clk(clk), .rst_n(rst_n), .rate(cfg_rate), .tick(tick)
   );

   sio_fifo #(.DW(8), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_data),
      .pop(txq_pop), .dout(txq_data), .full(tx_full), .empty(tx_empty)
   );

   sio_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_len(cfg_len),
      .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop),
      .q_empty(tx_empty), .q_data(txq_data), .q_pop(txq_pop), .tx_line(tx_line)
   );

   sio_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx_line(rx_line),
      .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .word_valid(rxw_valid), .word(rxw)
   );

   always_comb begin
      rx_done    = rxw_valid && !rx_full;
      rx_overrun = rxw_valid && rx_full;
   end

   logic [RXW-1:0] rxq_dout;

   sio_fifo #(.DW(RXW), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_done), .din(rxw),
      .pop(rx_pop), .dout(rxq_dout), .full(rx_full), .empty(rx_empty)
   );

   always_comb begin
      rxq_head = rx_word_t'(rxq_dout);
      rx_data  = rxq_head.data;
      rx_perr  = rxq_head.perr;
      rx_ferr  = rxq_head.ferr;
   end
endmodule

// File: rtl/sio_core_chk.sv
module sio_core_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_empty,
   input logic rx_full,
   input logic rx_done,
   input logic rx_overrun,
   input logic rx_pop
);
   // R7: a stored word leaves the receive queue non-empty
   p_done_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_empty);

   // R8: an empty queue stays empty without a store
   p_empty_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_empty && !rx_done) |=> rx_empty);

   // R8: a full queue stays full without a pop
   p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rx_pop) |=> rx_full);

   // R9: a drop only happens while the queue is full
   p_overrun_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |-> rx_full);

   // R9: a dropped word is never also reported as stored
   p_drop_not_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |-> !rx_done);
endmodule

bind sio_core sio_core_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rx_empty(rx_empty), .rx_full(rx_full),
   .rx_done(rx_done), .rx_overrun(rx_overrun), .rx_pop(rx_pop)
);

// File: tb/tb_sio_core.sv
module tb_sio_core;
   localparam int CLK_PERIOD = 10;
   localparam int DIVF = 2;
   localparam int TXD  = 4;
   localparam int RXD  = 4;

   logic clk = 0, rst_n = 0;
   logic [1:0] cfg_rate = 2'd3, cfg_len = 2'd2, cfg_stop = 2'd0;
   logic cfg_par_en = 0, cfg_par_odd = 0;
   logic tx_push = 0, rx_pop = 0, rx_drv = 1;
   logic [7:0] tx_data = 0;
   logic tx_full, tx_empty, tx_line, rx_perr, rx_ferr, rx_empty, rx_full, rx_done, rx_overrun;
   logic [7:0] rx_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   sio_core #(.DIV_FAST(DIVF), .TX_DEPTH(TXD), .RX_DEPTH(RXD), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .cfg_len(cfg_len),
      .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop),
      .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full), .tx_empty(tx_empty),
      .tx_line(tx_line), .rx_line(rx_drv), .rx_pop(rx_pop), .rx_data(rx_data),
      .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_empty(rx_empty), .rx_full(rx_full),
      .rx_done(rx_done), .rx_overrun(rx_overrun)
   );

   int checks = 0, fails = 0;
   bit done_flag = 0;
   int done_cnt = 0, ovr_cnt = 0;
   logic [9:0] exp_q[$];   // frames sent, not yet stored
   logic [9:0] mq[$];      // model of the receive queue
   logic done_n = 0, ovr_n = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int per();
      return DIVF << (3 - int'(cfg_rate));
   endfunction

   function automatic logic [7:0] msk(input int n);
      return 8'((1 << n) - 1);
   endfunction

   // queue model: latch outputs away from the edge, apply at the edge
   always @(negedge clk) begin
      done_n <= rx_done;
      ovr_n  <= rx_overrun;
   end

   always @(posedge clk) if (rst_n) begin
      if (ovr_n) begin
         ovr_cnt++;
         chk(mq.size() == RXD, "R9 drop while not full", mq.size(), RXD);
         if (exp_q.size() > 0) void'(exp_q.pop_front());
      end
      if (rx_pop && mq.size() > 0) void'(mq.pop_front());
      if (done_n) begin
         done_cnt++;
         if (exp_q.size() == 0) chk(0, "R7 unexpected store", 1, 0);
         else mq.push_back(exp_q.pop_front());
      end
   end

   // per-clock comparison of the receive queue outputs
   always @(negedge clk) if (rst_n) begin
      logic ok;
      ok = (rx_empty == (mq.size() == 0)) && (rx_full == (mq.size() == RXD));
      if (ok && mq.size() > 0) ok = ({rx_ferr, rx_perr, rx_data} == mq[0]);
      chk(ok, "R8 R3 rx queue head/status",
          {rx_empty, rx_full, rx_ferr, rx_perr, rx_data},
          {(mq.size() == 0), (mq.size() == RXD), (mq.size() > 0) ? mq[0] : 10'h0});
   end

   task automatic drive(input logic v, input int n);
      rx_drv = v;
      repeat (n) @(negedge clk);
   endtask

   // bench serialiser on the receive line
   task automatic send_rx(input logic [7:0] d, input bit bad_par, input bit bad_stop);
      int P, B, n;
      logic [7:0] dm;
      logic pb;
      P = per(); B = 16 * P;
      n = (cfg_len == 0) ? 6 : (cfg_len == 1) ? 7 : 8;
      dm = d & msk(n);
      drive(0, B);
      for (int i = 0; i < n; i++) drive(dm[i], B);
      pb = (^dm) ^ cfg_par_odd ^ bad_par;
      if (cfg_par_en) drive(pb, B);
      exp_q.push_back({bad_stop, cfg_par_en & bad_par, dm});
      if (bad_stop) begin drive(0, 12 * P); drive(1, 2 * B); end
      else drive(1, 2 * B);
      chk(exp_q.size() == 0, "R7 frame stored", exp_q.size(), 0);
   endtask

   task automatic pop1();
      @(negedge clk) rx_pop = 1;
      @(negedge clk) rx_pop = 0;
   endtask

   // bench deserialiser on the transmit line
   task automatic cap(input logic [7:0] w, input int n, input bit pen, input bit podd,
                      input int stop_t, input bit gap);
      int P, c;
      logic [7:0] got;
      P = per(); got = 0;
      while (tx_line) @(negedge clk);
      repeat (8 * P) @(negedge clk);
      chk(tx_line == 0, "R2 start bit low", tx_line, 0);
      for (int i = 0; i < n; i++) begin
         repeat (16 * P) @(negedge clk);
         got[i] = tx_line;
      end
      chk(got == (w & msk(n)), "R3 tx data lsb first", got, w & msk(n));
      if (pen) begin
         repeat (16 * P) @(negedge clk);
         chk(tx_line == ((^(w & msk(n))) ^ podd), "R4 tx parity", tx_line, (^(w & msk(n))) ^ podd);
      end
      repeat (16 * P) @(negedge clk);
      chk(tx_line == 1, "R2 stop bit high", tx_line, 1);
      if (gap) begin
         c = 0;
         while (tx_line && c < 64 * P) begin @(negedge clk); c++; end
         chk(c == (stop_t - 8) * P, "R5 R1 stop time", c, (stop_t - 8) * P);
      end
   endtask

   task automatic push_words(input logic [7:0] a, input logic [7:0] b, input int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk); tx_push = 1; tx_data = (i == 0) ? a : b;
      end
      @(negedge clk); tx_push = 0;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] acc[$];
      int base, P;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(tx_line == 1, "R2 idle after reset", tx_line, 1);
      chk(tx_empty && !tx_full, "R8 tx queue reset", {tx_empty, tx_full}, 2'b10);
      chk(rx_empty && !rx_full && !rx_done && !rx_overrun, "R7 rx reset",
          {rx_empty, rx_full, rx_done, rx_overrun}, 4'b1000);

      // 8 data bits, no parity, 1 stop, fastest rate
      fork
         push_words(8'hA5, 8'h3C, 2);
         begin cap(8'hA5, 8, 0, 0, 16, 1); cap(8'h3C, 8, 0, 0, 16, 0); end
      join
      // 7 data bits, even parity, 1.5 stop, rate 2
      cfg_rate = 2; cfg_len = 1; cfg_par_en = 1; cfg_par_odd = 0; cfg_stop = 1;
      fork
         push_words(8'h5B, 8'h21, 2);
         begin cap(8'h5B, 7, 1, 0, 24, 1); cap(8'h21, 7, 1, 0, 24, 0); end
      join
      // 6 data bits, odd parity, 2 stop, fastest rate
      cfg_rate = 3; cfg_len = 0; cfg_par_odd = 1; cfg_stop = 2;
      fork
         push_words(8'hF7, 8'h2A, 2);
         begin cap(8'hF7, 6, 1, 1, 32, 1); cap(8'h2A, 6, 1, 1, 32, 0); end
      join
      // slower rate scales bit time, R1
      cfg_rate = 1; cfg_len = 2; cfg_par_en = 0; cfg_stop = 0;
      fork
         push_words(8'h81, 8'h7E, 2);
         begin cap(8'h81, 8, 0, 0, 16, 1); cap(8'h7E, 8, 0, 0, 16, 0); end
      join
      // push into a full transmit queue, R8
      cfg_rate = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (!tx_full) acc.push_back(8'(8'h10 + i));
         tx_push = 1; tx_data = 8'(8'h10 + i);
      end
      @(negedge clk); tx_push = 0;
      chk(acc.size() < 8, "R8 push while full ignored", acc.size(), TXD);
      cfg_rate = 3;
      while (acc.size() > 0) cap(acc.pop_front(), 8, 0, 0, 16, 0);
      P = per();
      begin
         bit stayed = 1;
         repeat (40 * P) begin @(negedge clk); if (!tx_line) stayed = 0; end
         chk(stayed, "R8 no extra frame sent", stayed, 1);
      end
      // configuration change mid-frame, R12
      fork
         push_words(8'hC3, 8'hC3, 1);
         cap(8'hC3, 8, 0, 0, 16, 0);
         begin repeat (48 * P) @(negedge clk); cfg_len = 0; cfg_par_en = 1; end
      join
      cfg_len = 2; cfg_par_en = 0;
      repeat (20 * P) @(negedge clk);
      chk(tx_line == 1 && tx_empty, "R12 frame kept format", tx_line, 1);

      // receive paths
      send_rx(8'hA5, 0, 0); pop1();
      send_rx(8'h96, 0, 0); pop1();
      cfg_len = 1; cfg_par_en = 1; cfg_par_odd = 0;
      send_rx(8'h4D, 0, 0); pop1();
      cfg_len = 0; cfg_par_odd = 1;
      send_rx(8'hFF, 0, 0); pop1();
      cfg_rate = 1; cfg_len = 2; cfg_par_en = 0;
      send_rx(8'h3E, 0, 0); pop1();
      cfg_rate = 3; cfg_par_en = 1; cfg_par_odd = 0;
      send_rx(8'h71, 1, 0); pop1();                       // R11
      cfg_par_en = 0;
      send_rx(8'h0F, 0, 1); pop1();                       // R10
      // short low pulse is not a start, R6
      base = done_cnt;
      drive(0, 4 * P); drive(1, 40 * P);
      chk(done_cnt == base && rx_empty, "R6 glitch rejected", done_cnt - base, 0);
      // overrun, R9
      base = ovr_cnt;
      for (int i = 0; i < RXD + 1; i++) send_rx(8'(8'h40 + i), 0, 0);
      chk(ovr_cnt == base + 1, "R9 overrun pulse", ovr_cnt - base, 1);
      for (int i = 0; i < RXD + 1; i++) pop1();            // last pop on empty, R8
      repeat (4) @(negedge clk);
      chk(rx_empty && mq.size() == 0, "R8 drained", rx_empty, 1);
      finish_run();
   end
endmodule